// File: doc/BRIEF.md
# Power Control Register with Self-Clearing Initialization

This block holds the four power-management bits of a display driver: amplifier enable, power-saving halt, booster enable and an initialization request. A host writes and reads them through a simple register port at one fixed address. The stored bits are turned into enable lines for the oscillator, the power circuit, the external clock input, the booster and the amplifier, and into a force-low line for the segment and common drivers.

Setting the initialization bit launches a reset pulse for the display logic. The request crosses into the display-clock domain through a two-flop synchronizer. A small sequencer there emits a pulse of a fixed number of display clocks, and its activity is carried back to the host domain. The request bit clears itself once the pulse has begun. A busy flag tells the host when the whole handshake has settled, and so when it may issue its next operation. A halt leaves every stored bit as it was, so the settings come back unchanged when the halt is released.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After reset, all four control bits read 0 at address 0xB, and busy_o and init_rst_o are 0.
- R2: A host write to address 0xB stores wdata bits [3:1]. Bit 3 is amplifier enable, bit 2 is halt and bit 1 is booster enable. A read at 0xB returns {amp, halt, boost, init} in bits [3:0] and 0 above them. A read at any other address returns 0, and a write to any other address changes nothing.
- R3: booster_en_o equals boost AND NOT halt, and amp_en_o equals amp AND NOT halt.
- R4: While halt is 1, osc_en_o, pwr_en_o and ext_clk_en_o are 0 and drv_low_o is 1. While halt is 0, the first three are 1 and drv_low_o is 0.
- R5: Setting and then clearing halt leaves the stored amplifier and booster bits unchanged.
- R6: Each accepted initialization request produces exactly one init_rst_o pulse, high for exactly RST_CYCLES display clocks (default 2).
- R7: A write with bit 0 set reads back 1 in bit 0 from the next host cycle on. The bit returns to 0 by itself only after init_rst_o has risen.
- R8: busy_o is 1 from the host cycle after an accepted request until the handshake has finished, and it is 1 whenever init_rst_o is 1.
- R9: While busy_o is 1, writing bit 0 as 1 starts no second pulse, and writing bit 0 as 0 does not cancel the pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| dclk_i | input | 1 | Display clock |
| host_addr_i | input | ADDR_W | Register address |
| host_we_i | input | 1 | Write strobe |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data (combinational on the address) |
| busy_o | output | 1 | Initialization handshake in progress |
| init_rst_o | output | 1 | Reset pulse in the display-clock domain |
| osc_en_o | output | 1 | Oscillator enable |
| pwr_en_o | output | 1 | Power circuit enable |
| ext_clk_en_o | output | 1 | External clock input enable |
| booster_en_o | output | 1 | Booster enable |
| amp_en_o | output | 1 | Amplifier enable |
| drv_low_o | output | 1 | Force driver outputs to the low supply |

## Verification
The hardest situation to reach is a second request that arrives while the first is still crossing between the clock domains. A repeat request or a cancel attempt that lands after the handshake has ended would simply be an ordinary new request. The stimulus therefore issues a repeat request and a zero-valued write in the host cycles right after the first request, while busy is certain to be high. A scoreboard then confirms that only one pulse, of the right length, comes out. The display clock runs at a period unrelated to the host clock, so the edges of the synchronizers drift against each other over the run.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int unsigned BIT_INIT  = 0;
  localparam int unsigned BIT_BOOST = 1;
  localparam int unsigned BIT_HALT  = 2;
  localparam int unsigned BIT_AMP   = 3;

  typedef struct packed {
    logic osc_en;
    logic pwr_en;
    logic ext_clk_en;
    logic booster_en;
    logic amp_en;
    logic drv_low;
  } pwr_out_t;

  // Maps stored bits to the power-saving controls.
  function automatic pwr_out_t decode_ctrl(input logic amp, input logic halt,
                                           input logic boost);
    pwr_out_t o;
    o.osc_en     = ~halt;
    o.pwr_en     = ~halt;
    o.ext_clk_en = ~halt;
    o.booster_en = boost & ~halt;
    o.amp_en     = amp & ~halt;
    o.drv_low    = halt;
    return o;
  endfunction
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_init_seq.sv
module pwr_init_seq #(
  parameter int unsigned RST_CYCLES = 2
) (
  input  logic dclk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic pulse_o,
  output logic active_o
);
  localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_DONE} seq_t;
  seq_t             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_cycle;

  assign last_cycle = (cnt_q == CNT_W'(RST_CYCLES - 1));

  always_ff @(posedge dclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE:  if (req_i) begin state_q <= S_PULSE; cnt_q <= '0; end
        S_PULSE: if (last_cycle) state_q <= S_DONE;
                 else cnt_q <= cnt_q + 1'b1;
        S_DONE:  if (!req_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign pulse_o  = (state_q == S_PULSE);
  assign active_o = (state_q != S_IDLE);

  // R6: the pulse never runs past its length and ends at the last count
  assert_pulse_bound_R6: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    pulse_o |-> (cnt_q < CNT_W'(RST_CYCLES)));
  assert_pulse_end_R6: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    $fell(pulse_o) |-> ($past(cnt_q) == CNT_W'(RST_CYCLES - 1)));
endmodule

// File: rtl/pwr_host_regs.sv
module pwr_host_regs #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned REG_ADDR = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              act_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [3:0]        ctrl_o,
  output logic              busy_o
);
  import pwr_pkg::*;

  logic [3:1] cfg_q;
  logic       init_q;
  logic       hit;
  logic       accept_init;

  assign hit         = (addr_i == ADDR_W'(REG_ADDR));
  assign busy_o      = init_q | act_i;
  assign accept_init = we_i & hit & wdata_i[BIT_INIT] & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      init_q <= 1'b0;
    end else begin
      if (we_i && hit) cfg_q <= wdata_i[3:1];
      if (accept_init)  init_q <= 1'b1;
      else if (act_i)   init_q <= 1'b0;
    end
  end

  assign ctrl_o  = {cfg_q, init_q};
  assign rdata_o = hit ? DATA_W'(ctrl_o) : '0;

  // R7: the request bit drops only once the pulse has been seen to start
  assert_init_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_q) |-> $past(act_i));
  // R2: stored bits move only on a write to the register address
  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && hit) |=> $stable(cfg_q));
  // R9: a pending request is not restarted or cancelled by host writes
  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && !act_i) |=> init_q);
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned REG_ADDR   = 11,
  parameter int unsigned RST_CYCLES = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dclk_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_we_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              busy_o,
  output logic              init_rst_o,
  output logic              osc_en_o,
  output logic              pwr_en_o,
  output logic              ext_clk_en_o,
  output logic              booster_en_o,
  output logic              amp_en_o,
  output logic              drv_low_o
);
  import pwr_pkg::*;

  logic [3:0] ctrl;
  logic       req_dclk;
  logic       act_dclk;
  logic       act_host;
  pwr_out_t   pout;

  pwr_host_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(host_addr_i), .we_i(host_we_i),
    .wdata_i(host_wdata_i), .act_i(act_host), .rdata_o(host_rdata_o),
    .ctrl_o(ctrl), .busy_o(busy_o)
  );

  pwr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(dclk_i), .rst_ni(rst_ni), .d_i(ctrl[BIT_INIT]), .q_o(req_dclk)
  );

  pwr_init_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .dclk_i(dclk_i), .rst_ni(rst_ni), .req_i(req_dclk),
    .pulse_o(init_rst_o), .active_o(act_dclk)
  );

  pwr_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(act_dclk), .q_o(act_host)
  );

  assign pout         = decode_ctrl(ctrl[BIT_AMP], ctrl[BIT_HALT], ctrl[BIT_BOOST]);
  assign osc_en_o     = pout.osc_en;
  assign pwr_en_o     = pout.pwr_en;
  assign ext_clk_en_o = pout.ext_clk_en;
  assign booster_en_o = pout.booster_en;
  assign amp_en_o     = pout.amp_en;
  assign drv_low_o    = pout.drv_low;

  // R3: booster and amplifier are never on during halt
  assert_halt_gates_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (booster_en_o || amp_en_o) |-> !drv_low_o);
  // R8: the pulse only runs while the host sees busy
  assert_busy_pulse_R8: assert property (@(posedge dclk_i) disable iff (!rst_ni)
    init_rst_o |-> busy_o);
endmodule

// File: tb/pwr_ctl_reg_tb.sv
module pwr_ctl_reg_tb;
  localparam int unsigned RSTC = 2;

  logic       clk = 1'b0, dclk = 1'b0, rst_n = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h0, rdata;
  logic busy, init_rst, osc_en, pwr_en, ext_en, boost_en, amp_en, drv_low;

  int checks = 0, errors = 0, pulses = 0, run = 0, expected_pulses = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 clk = ~clk;
  always #11 dclk = ~dclk;

  pwr_ctl_reg #(.RST_CYCLES(RSTC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk), .host_addr_i(addr),
    .host_we_i(we), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .busy_o(busy), .init_rst_o(init_rst), .osc_en_o(osc_en), .pwr_en_o(pwr_en),
    .ext_clk_en_o(ext_en), .booster_en_o(boost_en), .amp_en_o(amp_en),
    .drv_low_o(drv_low)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; addr = 4'hB;
  endtask

  // driver side of the scoreboard: one expected pulse length per accepted request
  task automatic request_init(input logic [7:0] d);
    wr(4'hB, d);
    exp_q.push_back(RSTC);
    expected_pulses++;
  endtask

  task automatic check_outputs(input string req, input logic amp, input logic halt,
                               input logic bst);
    #1;
    check(req, {osc_en, pwr_en, ext_en, drv_low}, halt ? 4'b0001 : 4'b1110);
    check(req, {boost_en, amp_en}, {bst & ~halt, amp & ~halt});
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  // monitor: measures each pulse on the display clock and compares to the queue
  always @(negedge dclk) begin
    if (init_rst) begin
      if (run == 0) begin
        pulses++;
        check("R8 busy during pulse", busy, 1);
      end
      run++;
    end else if (run > 0) begin
      if (exp_q.size() == 0) check("R9 unexpected pulse", run, 0);
      else check("R6 pulse length", run, exp_q.pop_front());
      run = 0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    addr = 4'hB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 reset readback", rdata, 8'h00);
    check("R1 reset busy/init", {busy, init_rst}, 2'b00);
    check_outputs("R4 reset outputs", 0, 0, 0);

    wr(4'hB, 8'h0A);
    #1 check("R2 readback", rdata, 8'h0A);
    check_outputs("R3 amp+boost on", 1, 0, 1);

    wr(4'h3, 8'h00);
    #1 check("R2 other-address write ignored", rdata, 8'h0A);
    addr = 4'h3; #1 check("R2 other-address read", rdata, 8'h00);
    addr = 4'hB;

    wr(4'hB, 8'h0E);
    #1 check("R5 readback in halt", rdata, 8'h0E);
    check_outputs("R4 halt outputs", 1, 1, 1);
    wr(4'hB, 8'h0A);
    #1 check("R5 settings restored", rdata, 8'h0A);
    check_outputs("R3 after halt", 1, 0, 1);

    wr(4'hB, 8'h04);
    check_outputs("R3 halt only", 0, 1, 0);
    wr(4'hB, 8'h0A);

    request_init(8'h0B);
    #1 check("R7 init bit set", rdata, 8'h0B);
    check("R8 busy after request", busy, 1);
    check("R7 no early clear", pulses, 0);
    while (rdata[0] === 1'b1) begin @(negedge clk); #1; end
    check("R7 cleared after pulse start", pulses >= 1, 1);
    wait_idle();
    #1 check("R7 final readback", rdata, 8'h0A);
    check("R6 one pulse", pulses, 1);

    request_init(8'h03);
    wr(4'hB, 8'h03);
    wr(4'hB, 8'h02);
    #1 check("R9 pending kept", rdata[0], 1);
    wait_idle();
    check("R9 single pulse", pulses, 2);
    #1 check("R9 readback", rdata, 8'h02);

    request_init(8'h01);
    wait_idle();
    check("R6 total pulses", pulses, expected_pulses);
    check("R6 scoreboard drained", exp_q.size(), 0);
    check("R8 busy clear at end", busy, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule